// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block keeps the 15-bit word address of a byte-wide serial memory. A host loads the address as two received bytes, upper part first, then lower part. After every data byte the address steps forward by one, and the way it steps depends on the operation in progress.

In write mode only the six offset bits inside a 64-byte page advance, so a long burst circles within one page and overwrites its earlier bytes. In read mode the whole address advances and runs from the last byte of memory back to zero. Between transactions the value is held, so a read that sends no address resumes from the byte after the last one touched.

Top module: `wa_addr_counter`

## Requirements
- R1: While rst_ni is low, and after its release with no other stimulus, addr_o is 0.
- R2: A cycle with load_hi_i high writes data_i[6:0] into addr_o[14:8]. data_i[7] has no effect.
- R3: A cycle with load_lo_i high writes data_i[7:0] into addr_o[7:0]. Both loads may occur in the same cycle.
- R4: In a cycle with either load high, inc_i is ignored. The address takes only the loaded fields, and the other bits keep their value.
- R5: With wr_mode_i = 1 (write), an inc_i cycle adds one to addr_o[5:0] and leaves addr_o[14:6] unchanged.
- R6: In write mode an increment from offset 6'h3F gives offset 0 in the same page. After 64 increments the address is back at its start.
- R7: With wr_mode_i = 0 (read), an inc_i cycle adds one to the full 15-bit address, carrying across page and byte boundaries.
- R8: In read mode an increment from 15'h7FFF gives 0.
- R9: With no load and no increment, addr_o keeps its value whatever wr_mode_i and data_i do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_hi_i | input | 1 | Load upper address byte from data_i |
| load_lo_i | input | 1 | Load lower address byte from data_i |
| data_i | input | 8 | Received address byte |
| inc_i | input | 1 | Advance after a data byte |
| wr_mode_i | input | 1 | 1 = write (page wrap), 0 = read (full wrap) |
| addr_o | output | 15 | Current word address |

## Verification
Write-mode increments run through an offset of 6'h3F and then through a full 64-byte lap. These separate a page-local wrap from a carry into the page bits. Read-mode increments run from 8'hFE across a byte carry and across a page carry, and then from 15'h7FFF. These show that the full address advances and wraps to zero. Loads use a set data_i[7] and are applied together with inc_i, and idle cycles toggle the mode and data inputs. These catch a leaking don't-care bit, a wrong priority, or drift while idle.

// File: rtl/wa_pkg.sv
package wa_pkg;
  parameter int unsigned ADDR_W = 15;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned OFS_W  = 6;
endpackage

// File: rtl/wa_offset_cnt.sv
module wa_offset_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (inc_i) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & (&cnt_q);
endmodule

// File: rtl/wa_page_cnt.sv
module wa_page_cnt #(
  parameter int unsigned LO_W = 2,
  parameter int unsigned HI_W = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ld_lo_i,
  input  logic [LO_W-1:0]      lo_val_i,
  input  logic                 ld_hi_i,
  input  logic [HI_W-1:0]      hi_val_i,
  input  logic                 step_i,
  output logic [LO_W+HI_W-1:0] cnt_o
);
  localparam int unsigned W = LO_W + HI_W;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_lo_i || ld_hi_i) begin
      if (ld_lo_i) cnt_q[LO_W-1:0] <= lo_val_i;
      if (ld_hi_i) cnt_q[W-1:LO_W] <= hi_val_i;
    end else if (step_i) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wa_addr_counter.sv
module wa_addr_counter
  import wa_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned OW = OFS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_hi_i,
  input  logic          load_lo_i,
  input  logic [BW-1:0] data_i,
  input  logic          inc_i,
  input  logic          wr_mode_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned HI_W = AW - BW;   // bits taken from first byte
  localparam int unsigned PLO_W = BW - OW;  // page bits taken from second byte
  localparam int unsigned PG_W = AW - OW;

  logic          any_ld;
  logic          inc_eff;
  logic          ofs_wrap;
  logic [OW-1:0] ofs;
  logic [PG_W-1:0] page;

  assign any_ld  = load_hi_i | load_lo_i;
  assign inc_eff = inc_i & ~any_ld;

  wa_offset_cnt #(.W(OW)) u_ofs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (load_lo_i),
    .ld_val_i (data_i[OW-1:0]),
    .inc_i    (inc_eff),
    .cnt_o    (ofs),
    .wrap_o   (ofs_wrap)
  );

  // page carries only in read mode; write mode stays inside the page
  wa_page_cnt #(.LO_W(PLO_W), .HI_W(HI_W)) u_page (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_lo_i  (load_lo_i),
    .lo_val_i (data_i[BW-1:OW]),
    .ld_hi_i  (load_hi_i),
    .hi_val_i (data_i[HI_W-1:0]),
    .step_i   (ofs_wrap & ~wr_mode_i),
    .cnt_o    (page)
  );

  assign addr_o = {page, ofs};

  AST_LOAD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_hi_i |=> addr_o[AW-1:BW] == $past(data_i[HI_W-1:0])); // R2
  AST_LOAD_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_lo_i |=> addr_o[BW-1:0] == $past(data_i)); // R3
  AST_LOAD_KEEP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_hi_i && !load_lo_i) |=> addr_o[BW-1:0] == $past(addr_o[BW-1:0])); // R4
  AST_WR_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && wr_mode_i && !any_ld) |=> addr_o[AW-1:OW] == $past(addr_o[AW-1:OW])); // R5
  AST_WR_OFS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && wr_mode_i && !any_ld) |=> addr_o[OW-1:0] == OW'($past(addr_o[OW-1:0]) + 1'b1)); // R6
  AST_RD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_mode_i && !any_ld) |=> addr_o == AW'($past(addr_o) + 1'b1)); // R7
  AST_RD_TOP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_mode_i && !any_ld && (&addr_o)) |=> addr_o == '0); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !any_ld) |=> $stable(addr_o)); // R9
endmodule

// File: tb/wa_addr_counter_tb.sv
module wa_addr_counter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_hi_i = 1'b0;
  logic        load_lo_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        inc_i = 1'b0;
  logic        wr_mode_i = 1'b0;
  logic [14:0] addr_o;

  typedef struct {
    logic [14:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          n_chk = 0;
  int          n_err = 0;
  logic [14:0] model = '0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  wa_addr_counter u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_hi_i (load_hi_i),
    .load_lo_i (load_lo_i),
    .data_i    (data_i),
    .inc_i     (inc_i),
    .wr_mode_i (wr_mode_i),
    .addr_o    (addr_o)
  );

  task automatic check(input logic [14:0] exp, input string tag);
    n_chk++;
    if (addr_o !== exp) begin
      n_err++;
      $display("FAIL %s: addr_o=%h expected=%h", tag, addr_o, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the address the requirements predict
  task automatic step(input bit lh, input bit ll, input logic [7:0] d,
                      input bit inc, input bit wr, input string tag);
    item_t it;
    @(negedge clk_i);
    load_hi_i = lh; load_lo_i = ll; data_i = d; inc_i = inc; wr_mode_i = wr;
    @(posedge clk_i);
    if (lh || ll) begin
      if (lh) model[14:8] = d[6:0];
      if (ll) model[7:0]  = d;
    end else if (inc) begin
      if (wr) model[5:0] = model[5:0] + 6'd1;
      else    model      = model + 15'd1;
    end
    #1;
    it.exp = model;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.exp, it.tag);
      end
    end
  end

  initial begin
    #1 check(15'h0000, "R1 in reset");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i) check(15'h0000, "R1 after release");

    step(0, 0, 8'hFF, 0, 1, "R9 idle after reset");
    step(1, 0, 8'hA5, 0, 1, "R2 load hi, bit7 ignored");
    step(0, 1, 8'h3D, 0, 1, "R3 load lo");
    step(0, 0, 8'h00, 1, 1, "R5 write inc");
    step(0, 0, 8'h00, 1, 1, "R5 write inc to 3F");
    step(0, 0, 8'h00, 1, 1, "R6 write wrap in page");
    for (int i = 0; i < 64; i++) step(0, 0, 8'h00, 1, 1, "R6 write lap");
    step(0, 1, 8'hFE, 0, 0, "R3 load lo FE");
    step(0, 0, 8'h00, 1, 0, "R7 read inc");
    step(0, 0, 8'h00, 1, 0, "R7 read carry to high byte");
    step(0, 1, 8'h7F, 0, 0, "R3 load lo 7F");
    step(0, 0, 8'h00, 1, 0, "R7 read carry into next page");
    step(1, 1, 8'hFF, 0, 0, "R3 dual load");
    step(0, 0, 8'h00, 1, 1, "R6 write wrap at top page");
    step(0, 1, 8'hFF, 0, 0, "R3 reload lo FF");
    step(0, 0, 8'h00, 1, 0, "R8 read wrap to zero");
    step(1, 0, 8'h92, 1, 0, "R4 load hi beats inc");
    step(0, 1, 8'h3F, 1, 1, "R4 load lo beats inc");
    step(1, 1, 8'h81, 1, 0, "R4 dual load beats inc");
    step(0, 0, 8'h55, 0, 1, "R9 idle write mode");
    step(0, 0, 8'hAA, 0, 0, "R9 idle read mode");
    step(0, 0, 8'hFF, 0, 1, "R9 idle again");
    step(0, 0, 8'h00, 1, 0, "R7 resume after idle");
    @(negedge clk_i);
    load_hi_i = 0; load_lo_i = 0; inc_i = 0;
    repeat (2) @(negedge clk_i);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule